// File: doc/BRIEF.md
# Two-Level Interrupt Aggregator

This block gathers interrupt requests in two tiers and drives one interrupt line. The lower tier has two 32-bit groups: a USB-core group and a DMA group. Each group has a pending register and a mask register. Software changes them through three write actions: set, clear and mask. The upper tier is a 32-bit top-level pending register with its own mask. Three of its bits are not stored. They are summaries computed from the lower tier. The USB-core group splits by halfword into a transmit summary and a receive summary, and the DMA group folds into a single completion summary.

Other blocks raise pending bits directly through three event-set input vectors, one for each register group. A polarity bit in the control register chooses the output sense. When the bit is set, the line is high if any unmasked top-level bit is pending. When it is clear, the line is high only while nothing unmasked is pending. A power-good input gates the line, so it stays low while the device is powering up. Register reads are combinational from a word index, and the output follows the register state with no extra pipeline stage.

Top module: `hier_irq_agg`

## Requirements
- R1: After synchronous reset, every pending register reads 0, every mask register reads 0xFFFFFFFF, and the control register reads 0.
- R2: Each group has four word indices: pending at base+0, set at base+1, clear at base+2 and mask at base+3. The bases are 0 for the top level, 4 for the USB core and 8 for DMA. A write to set ORs the data into pending. A write to clear ANDs pending with the inverted data. A write to mask replaces the mask. Reads of the pending, set and clear indices all return the pending bits.
- R3: Top-level bit 9 reads 1 exactly when some USB-core pending bit in [15:0] is unmasked. Top-level bit 8 reads 1 exactly when some unmasked USB-core pending bit lies in [31:16].
- R4: Top-level bit 24 reads 1 exactly when any DMA pending bit is unmasked.
- R5: The control register sits at word index 12, and only its bit 17 (polarity) is stored. With polarity 1 and power good, irq_out is 1 exactly when some top-level pending bit is unmasked. With polarity 0 and power good, irq_out is 1 exactly when no top-level pending bit is unmasked.
- R6: irq_out is 0 whenever pwr_ok is 0.
- R7: A 1 on any bit of an event-set input sets that pending bit of its group at the next edge. The top-level event bits include 16 (timer expiry), 15 (bus-voltage change) and 12 (device ready). If a clear write hits the same bit in the same cycle, the event wins.
- R8: Top-level bits 8, 9 and 24 hold no state. Top-level set or clear writes and top-level events at those positions have no effect on them, so a summary stays 1 while its cause remains.
- R9: A register write changes irq_out and the read data within the same cycle after the clock edge that takes the write.
- R10: Word indices 13 to 15 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| top_evt | input | 32 | Event-set bits for the top-level pending register |
| core_evt | input | 32 | Event-set bits for the USB-core group |
| dma_evt | input | 32 | Event-set bits for the DMA group |
| pwr_ok | input | 1 | Interrupt enable, low during power-up |
| irq_out | output | 1 | Aggregated interrupt line |

## Verification
The hardest situation to reach is a top-level summary bit that the software tries to clear while its cause is still active and unmasked, under each polarity setting. Reaching it needs a lower-tier pending bit, a lower-tier mask that lets that bit through, and a top-level mask that exposes the summary, all at once. Random streams seldom line these up. Directed sequences therefore build the state step by step: set a core or DMA bit, open its mask, open the top-level mask, and then write the top-level clear. A seeded random sequence then mixes writes to every index, including unmapped ones, with sparse events and random masks, so that summaries rise and fall through both the mask path and the pending path.

// File: rtl/hia_pkg.sv
package hia_pkg;

    localparam int DW     = 32;
    localparam int AW     = 4;
    localparam int HALF_W = DW / 2;

    localparam int TX_SUM_BIT  = 9;
    localparam int RX_SUM_BIT  = 8;
    localparam int DMA_SUM_BIT = 24;
    localparam int POL_BIT     = 17;

    typedef enum logic [AW-1:0] {
        RI_TOP_SRC  = 4'd0,
        RI_TOP_SET  = 4'd1,
        RI_TOP_CLR  = 4'd2,
        RI_TOP_MSK  = 4'd3,
        RI_CORE_SRC = 4'd4,
        RI_CORE_SET = 4'd5,
        RI_CORE_CLR = 4'd6,
        RI_CORE_MSK = 4'd7,
        RI_DMA_SRC  = 4'd8,
        RI_DMA_SET  = 4'd9,
        RI_DMA_CLR  = 4'd10,
        RI_DMA_MSK  = 4'd11,
        RI_CTRL     = 4'd12,
        RI_RSV13    = 4'd13,
        RI_RSV14    = 4'd14,
        RI_RSV15    = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic msk;
    } grp_wr_t;

    function automatic logic [DW-1:0] summary_bits();
        logic [DW-1:0] v;
        v = '0;
        v[TX_SUM_BIT]  = 1'b1;
        v[RX_SUM_BIT]  = 1'b1;
        v[DMA_SUM_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/hia_group.sv
module hia_group
    import hia_pkg::*;
#(
    parameter int W = DW,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  grp_wr_t      wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] evt,
    output logic [W-1:0] pend,
    output logic [W-1:0] mask
);

    logic [W-1:0] set_v;
    logic [W-1:0] clr_v;

    always_comb begin
        set_v = wr.set ? wdata : '0;
        clr_v = wr.clr ? wdata : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= ((pend & ~clr_v) | set_v | evt) & KEEP;
            if (wr.msk) begin
                mask <= wdata;
            end
        end
    end

endmodule

// File: rtl/hia_summary.sv
module hia_summary
    import hia_pkg::*;
(
    input  logic [DW-1:0] core_pend,
    input  logic [DW-1:0] core_mask,
    input  logic [DW-1:0] dma_pend,
    input  logic [DW-1:0] dma_mask,
    output logic [DW-1:0] sum_vec
);

    logic [DW-1:0] core_live;
    logic [DW-1:0] dma_live;

    always_comb begin
        core_live = core_pend & ~core_mask;
        dma_live  = dma_pend & ~dma_mask;
        sum_vec   = '0;
        sum_vec[TX_SUM_BIT]  = |core_live[HALF_W-1:0];
        sum_vec[RX_SUM_BIT]  = |core_live[DW-1:HALF_W];
        sum_vec[DMA_SUM_BIT] = |dma_live;
    end

endmodule

// File: rtl/hia_regdec.sv
module hia_regdec
    import hia_pkg::*;
(
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] top_view,
    input  logic [DW-1:0] top_mask,
    input  logic [DW-1:0] core_pend,
    input  logic [DW-1:0] core_mask,
    input  logic [DW-1:0] dma_pend,
    input  logic [DW-1:0] dma_mask,
    input  logic          pol,
    output grp_wr_t       top_wr,
    output grp_wr_t       core_wr,
    output grp_wr_t       dma_wr,
    output logic          ctrl_wr,
    output logic [DW-1:0] rdata
);

    reg_idx_e idx;

    always_comb begin
        idx     = reg_idx_e'(reg_addr);
        top_wr  = '{set: reg_wr && idx == RI_TOP_SET,  clr: reg_wr && idx == RI_TOP_CLR,
                    msk: reg_wr && idx == RI_TOP_MSK};
        core_wr = '{set: reg_wr && idx == RI_CORE_SET, clr: reg_wr && idx == RI_CORE_CLR,
                    msk: reg_wr && idx == RI_CORE_MSK};
        dma_wr  = '{set: reg_wr && idx == RI_DMA_SET,  clr: reg_wr && idx == RI_DMA_CLR,
                    msk: reg_wr && idx == RI_DMA_MSK};
        ctrl_wr = reg_wr && idx == RI_CTRL;

        rdata = '0;
        case (idx)
            RI_TOP_SRC, RI_TOP_SET, RI_TOP_CLR:    rdata = top_view;
            RI_TOP_MSK:                            rdata = top_mask;
            RI_CORE_SRC, RI_CORE_SET, RI_CORE_CLR: rdata = core_pend;
            RI_CORE_MSK:                           rdata = core_mask;
            RI_DMA_SRC, RI_DMA_SET, RI_DMA_CLR:    rdata = dma_pend;
            RI_DMA_MSK:                            rdata = dma_mask;
            RI_CTRL:                               rdata[POL_BIT] = pol;
            default:                               rdata = '0;
        endcase
    end

endmodule

// File: rtl/hier_irq_agg.sv
module hier_irq_agg
    import hia_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [DW-1:0] top_evt,
    input  logic [DW-1:0] core_evt,
    input  logic [DW-1:0] dma_evt,
    input  logic          pwr_ok,
    output logic          irq_out
);

    localparam logic [DW-1:0] SUM_MASK = summary_bits();

    grp_wr_t       top_wr, core_wr, dma_wr;
    logic          ctrl_wr;
    logic          pol_q;
    logic [DW-1:0] top_pend, top_mask;
    logic [DW-1:0] core_pend, core_mask;
    logic [DW-1:0] dma_pend, dma_mask;
    logic [DW-1:0] sum_vec;
    logic [DW-1:0] top_view;
    logic          any_live;

    hia_regdec u_dec (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .top_view  (top_view),
        .top_mask  (top_mask),
        .core_pend (core_pend),
        .core_mask (core_mask),
        .dma_pend  (dma_pend),
        .dma_mask  (dma_mask),
        .pol       (pol_q),
        .top_wr    (top_wr),
        .core_wr   (core_wr),
        .dma_wr    (dma_wr),
        .ctrl_wr   (ctrl_wr),
        .rdata     (reg_rdata)
    );

    hia_group #(.W(DW), .KEEP(~SUM_MASK)) u_top (
        .clk (clk), .rst (rst), .wr (top_wr), .wdata (reg_wdata),
        .evt (top_evt), .pend (top_pend), .mask (top_mask)
    );

    hia_group #(.W(DW)) u_core (
        .clk (clk), .rst (rst), .wr (core_wr), .wdata (reg_wdata),
        .evt (core_evt), .pend (core_pend), .mask (core_mask)
    );

    hia_group #(.W(DW)) u_dma (
        .clk (clk), .rst (rst), .wr (dma_wr), .wdata (reg_wdata),
        .evt (dma_evt), .pend (dma_pend), .mask (dma_mask)
    );

    hia_summary u_sum (
        .core_pend (core_pend),
        .core_mask (core_mask),
        .dma_pend  (dma_pend),
        .dma_mask  (dma_mask),
        .sum_vec   (sum_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= 1'b0;
        end else if (ctrl_wr) begin
            pol_q <= reg_wdata[POL_BIT];
        end
    end

    always_comb begin
        top_view = top_pend | sum_vec;
        any_live = |(top_view & ~top_mask);
        irq_out  = pwr_ok & (pol_q ? any_live : ~any_live);
    end

endmodule

// File: rtl/hia_checker.sv
module hia_checker
    import hia_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] top_evt,
    input logic [DW-1:0] dma_evt,
    input logic          pwr_ok,
    input logic          irq_out,
    input logic [DW-1:0] top_view,
    input logic [DW-1:0] top_mask,
    input logic [DW-1:0] core_pend,
    input logic [DW-1:0] core_mask,
    input logic [DW-1:0] dma_pend,
    input logic [DW-1:0] dma_mask
);

    localparam logic [DW-1:0] SUM_MASK = summary_bits();

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (top_mask == '1 && core_mask == '1 && dma_mask == '1 &&
                        core_pend == '0 && dma_pend == '0)); // R1

    AST_CORE_SET_OR: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RI_CORE_SET) |=>
            ((core_pend & $past(reg_wdata)) == $past(reg_wdata))); // R2

    AST_DMA_CLR_AND: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RI_DMA_CLR && dma_evt == '0) |=>
            ((dma_pend & $past(reg_wdata)) == '0)); // R2

    AST_TX_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RI_CORE_SET && (|(reg_wdata[HALF_W-1:0] & ~core_mask[HALF_W-1:0])))
            |=> top_view[TX_SUM_BIT]); // R3

    AST_DMA_SUMMARY: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RI_DMA_SET && (|(reg_wdata & ~dma_mask)))
            |=> top_view[DMA_SUM_BIT]); // R4

    AST_PWR_GATE: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |-> !irq_out); // R6

    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|(top_evt & ~SUM_MASK)) |=>
            ((top_view & $past(top_evt & ~SUM_MASK)) == $past(top_evt & ~SUM_MASK))); // R7

endmodule

bind hier_irq_agg hia_checker u_hia_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .top_evt   (top_evt),
    .dma_evt   (dma_evt),
    .pwr_ok    (pwr_ok),
    .irq_out   (irq_out),
    .top_view  (top_view),
    .top_mask  (top_mask),
    .core_pend (core_pend),
    .core_mask (core_mask),
    .dma_pend  (dma_pend),
    .dma_mask  (dma_mask)
);

// File: tb/hier_irq_agg_tb_top.sv
module hier_irq_agg_tb_top;

    localparam logic [31:0] SUMS = (32'h1 << 9) | (32'h1 << 8) | (32'h1 << 24);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] top_evt = '0, core_evt = '0, dma_evt = '0;
    logic        pwr_ok = 1'b1;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_top, m_tmask, m_core, m_cmask, m_dma, m_dmask;
    logic        m_pol;

    always #4 clk = ~clk;

    hier_irq_agg dut_i (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .top_evt (top_evt),
        .core_evt (core_evt), .dma_evt (dma_evt), .pwr_ok (pwr_ok), .irq_out (irq_out)
    );

    function automatic logic [31:0] exp_view();
        logic [31:0] v;
        logic [31:0] cl;
        cl = m_core & ~m_cmask;
        v = m_top;
        v[9]  = |cl[15:0];
        v[8]  = |cl[31:16];
        v[24] = |(m_dma & ~m_dmask);
        return v;
    endfunction

    function automatic logic exp_irq();
        logic any;
        any = |(exp_view() & ~m_tmask);
        return pwr_ok & (m_pol ? any : ~any);
    endfunction

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0, 4'd1, 4'd2:  return exp_view();
            4'd3:              return m_tmask;
            4'd4, 4'd5, 4'd6:  return m_core;
            4'd7:              return m_cmask;
            4'd8, 4'd9, 4'd10: return m_dma;
            4'd11:             return m_dmask;
            4'd12:             return {14'd0, m_pol, 17'd0};
            default:           return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [3:0] a);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    task automatic chk_irq(input string tag);
        #1;
        chk(tag, {31'd0, irq_out}, {31'd0, exp_irq()});
    endtask

    task automatic step(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        input logic [31:0] te, input logic [31:0] ce, input logic [31:0] de);
        logic [31:0] s, c;
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        top_evt = te; core_evt = ce; dma_evt = de;
        @(posedge clk);
        s = (wr && a == 4'd1) ? d : 32'd0;
        c = (wr && a == 4'd2) ? d : 32'd0;
        m_top = ((m_top & ~c) | s | te) & ~SUMS;
        s = (wr && a == 4'd5) ? d : 32'd0;
        c = (wr && a == 4'd6) ? d : 32'd0;
        m_core = (m_core & ~c) | s | ce;
        s = (wr && a == 4'd9) ? d : 32'd0;
        c = (wr && a == 4'd10) ? d : 32'd0;
        m_dma = (m_dma & ~c) | s | de;
        if (wr && a == 4'd3)  m_tmask = d;
        if (wr && a == 4'd7)  m_cmask = d;
        if (wr && a == 4'd11) m_dmask = d;
        if (wr && a == 4'd12) m_pol = d[17];
        #1;
        reg_wr = 1'b0; top_evt = '0; core_evt = '0; dma_evt = '0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        step(1'b1, a, d, '0, '0, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_top = '0; m_core = '0; m_dma = '0;
        m_tmask = '1; m_cmask = '1; m_dmask = '1; m_pol = 1'b0;
        r = $urandom(32'd4242);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 13; a++) chk_reg("R1 reset read", 4'(a));
        chk_irq("R1 reset irq");

        // R2 set/clear/mask and aliased reads
        wr_reg(4'd5, 32'h0001_8001);
        chk_reg("R2 core set", 4'd4);
        chk_reg("R2 core read at set index", 4'd5);
        chk_reg("R2 core read at clear index", 4'd6);
        wr_reg(4'd6, 32'h0000_8000);
        chk_reg("R2 core clear", 4'd4);
        wr_reg(4'd7, 32'hFFFF_FFFE);
        chk_reg("R2 core mask replace", 4'd7);

        // R3 TX summary, then R9 irq visible right after the write
        chk_reg("R3 tx summary set", 4'd0);
        wr_reg(4'd3, ~(32'h1 << 9));
        chk_irq("R9 irq after mask write");
        wr_reg(4'd12, 32'h0002_0000);
        chk_irq("R5 polarity high with pending");
        chk_reg("R5 ctrl readback", 4'd12);

        // R8 clear of an active summary has no effect
        wr_reg(4'd2, 32'hFFFF_FFFF);
        chk_reg("R8 summary survives clear", 4'd0);
        wr_reg(4'd1, SUMS);
        chk_reg("R8 set on summary ignored", 4'd0);

        // R3 RX summary via high half
        wr_reg(4'd7, 32'hFFFE_FFFF);
        chk_reg("R3 rx summary", 4'd0);

        // R4 DMA summary
        wr_reg(4'd9, 32'h0000_0010);
        chk_reg("R4 dma masked no summary", 4'd0);
        wr_reg(4'd11, 32'hFFFF_FFEF);
        chk_reg("R4 dma summary", 4'd0);
        wr_reg(4'd10, 32'h0000_0010);
        chk_reg("R4 dma summary cleared", 4'd0);

        // R6 power gating
        @(negedge clk); pwr_ok = 1'b0;
        chk_irq("R6 irq gated");
        @(negedge clk); pwr_ok = 1'b1;
        chk_irq("R6 irq restored");

        // R7 events, including event against clear in same cycle
        step(1'b0, 4'd0, 32'd0, (32'h1 << 16) | (32'h1 << 15) | (32'h1 << 12), '0, '0);
        chk_reg("R7 top events", 4'd0);
        step(1'b1, 4'd2, 32'h0001_0000, 32'h0001_0000, '0, '0);
        chk_reg("R7 event beats clear", 4'd0);
        step(1'b0, 4'd0, 32'd0, SUMS, 32'h0000_0004, 32'h0000_0100);
        chk_reg("R8 top event on summary ignored", 4'd0);
        chk_reg("R7 core event", 4'd4);
        chk_reg("R7 dma event", 4'd8);

        // R10 unmapped indices
        wr_reg(4'd13, 32'hFFFF_FFFF);
        chk_reg("R10 unmapped read 13", 4'd13);
        chk_reg("R10 unmapped write no effect", 4'd0);
        chk_reg("R10 unmapped read 15", 4'd15);

        // R5 polarity low with and without live bits
        wr_reg(4'd12, 32'h0);
        chk_irq("R5 polarity low");
        wr_reg(4'd3, 32'hFFFF_FFFF);
        chk_irq("R5 polarity low all masked");

        // random mix, R2 R3 R4 R5
        for (int i = 0; i < 400; i++) begin
            logic [3:0] a;
            logic [31:0] d, te, ce, de;
            a  = 4'($urandom_range(0, 15));
            d  = $urandom();
            if ($urandom_range(0, 2) == 0) d = d & $urandom();
            te = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'd0;
            ce = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'd0;
            de = ($urandom_range(0, 5) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'd0;
            step($urandom_range(0, 3) != 0, a, d, te, ce, de);
            chk_reg("R3 R4 random top view", 4'd0);
            chk_reg("R2 random read", 4'($urandom_range(0, 15)));
            chk_irq("R5 random irq");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule